// File: doc/BRIEF.md
# Chained Retriggerable Watchdog Counter Bank

This block holds four 64-bit down-counters behind a small 32-bit read/write register port. Each counter counts toward zero at a rate set by its own clock divider. It either runs once after being enabled, or waits for a trigger that reloads it and starts it again. The trigger for counter n is the end-count event of counter n−1. This lets a one-shot counter that is loaded with zero serve as a refresh source for a watchdog counter. The watchdog counter is then reloaded by hardware and is never switched off in order to refresh it.

A mask register picks which counters' expiry raises the watchdog reset output. That output is a pulse one clock wide. The 64-bit count is read as two 32-bit words. Reading the low word freezes the matching high word in a holding register, so the two halves always come from the same clock cycle.

Top module: `wdtb_top`

## Requirements
- R1: Counter n has its control word at byte address n*0x10. The control word has these fields: bit 0 enable, bit 1 running flag (read-only, writes ignored), bits 3:2 mode, bits 7:4 trigger source, bits 15:8 divider. Bits 31:16 read as zero. The watchdog mask register sits at 0x40 and uses bits 3:0.
- R2: A write to the low count word (n*0x10+0x4) is only staged. A write to the high word (n*0x10+0x8) loads the staged low word and the written high word together into both the reload value and the current count. A read of the low word returns the current count bits 31:0.
- R3: A read of the low word captures count bits 63:32 in the same cycle. A later read of the high word returns that captured value, even if the count has changed since.
- R4: A running counter decrements once every max(divider, 2) clocks, counted from the cycle in which it starts. Divider values 0 and 1 act as 2.
- R5: In mode 00 (one-shot), a write that changes enable from 0 to 1 copies the reload value into the count and sets the running flag. When a running counter reaches zero, it raises a one-cycle end event, clears the running flag and holds the count at zero.
- R6: In mode 11 (triggered), setting enable does not start the counter. With trigger source 0x5, the end event of counter n−1 reloads the count and starts the counter; counter 0 has no such source. At zero the counter raises its end event and stops.
- R7: A control write with enable 0 clears the running flag on that clock and freezes the count. A trigger that arrives while enable is 0 does not start the counter and does not change its count.
- R8: A one-shot counter loaded with zero produces its end event one cycle after it is enabled. Clearing and then setting its enable again restarts the triggered counter that follows it, with that counter's full reload value.
- R9: The watchdog reset output pulses high for one clock, one cycle after the end event of a counter whose mask bit is set. A mask of zero keeps the output low.
- R10: After reset, all control words, counts and the mask read as zero, and the watchdog reset output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for the low-word capture) |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The hardest case to reach from the ports is a refresh that lands while the watchdog counter is still running. It needs a zero-loaded one-shot neighbour, a triggered counter with the right source, and an enable toggle timed before expiry. The stimulus counts the clocks from the first start and reads the remaining count just before the refresh. It then toggles the neighbour's enable and reads the count back at its full reload value. Only after that does it let the counter expire, so the single reset pulse can be checked to the cycle. A second pass repeats the refresh with the watchdog counter disabled, and a third with the mask cleared, to show that both are ignored.

// File: rtl/wdtb_pkg.sv
package wdtb_pkg;

  localparam logic [3:0] CTRL_OFS   = 4'h0;
  localparam logic [3:0] LO_OFS     = 4'h4;
  localparam logic [3:0] HI_OFS     = 4'h8;
  localparam logic [1:0] MODE_TRIG  = 2'b11;
  localparam logic [3:0] SRC_PREV   = 4'h5;
  localparam int         DIV_W      = 8;
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  // Divider actually applied: anything below the minimum behaves as the minimum.
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] div);
    return (div < DIV_MIN) ? DIV_MIN : div;
  endfunction

  // True on the clock in which the count must step down.
  function automatic logic tick_due(input logic [DIV_W-1:0] phase,
                                    input logic [DIV_W-1:0] div);
    return phase >= (eff_div(div) - DIV_W'(1));
  endfunction

endpackage

// File: rtl/wdtb_counter.sv
module wdtb_counter
  import wdtb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic              rd_lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic              prev_end,
  output logic [DATA_W-1:0] ctrl_word,
  output logic [DATA_W-1:0] count_lo,
  output logic [DATA_W-1:0] hold_hi,
  output logic              end_evt
);

  localparam int CNT_W = 2 * DATA_W;

  logic              en_q;
  logic              active_q;
  logic [1:0]        mode_q;
  logic [3:0]        src_q;
  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  phase_q;
  logic [CNT_W-1:0]  count_q;
  logic [CNT_W-1:0]  reload_q;
  logic [DATA_W-1:0] stage_q;
  logic [DATA_W-1:0] hold_q;

  logic trig_hit;
  logic step;
  logic start_req;

  assign end_evt   = active_q && (count_q == '0);
  assign trig_hit  = en_q && (mode_q == MODE_TRIG) && (src_q == SRC_PREV) && prev_end;
  assign step      = tick_due(phase_q, div_q);
  assign start_req = ctrl_we && wdata[0] && !en_q && (wdata[3:2] != MODE_TRIG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      active_q <= 1'b0;
      mode_q   <= '0;
      src_q    <= '0;
      div_q    <= '0;
      phase_q  <= '0;
      count_q  <= '0;
      reload_q <= '0;
      stage_q  <= '0;
      hold_q   <= '0;
    end else begin
      // countdown, lowest priority
      if (active_q) begin
        if (count_q == '0) begin
          active_q <= 1'b0;
        end else if (step) begin
          count_q <= count_q - CNT_W'(1);
          phase_q <= '0;
        end else begin
          phase_q <= phase_q + DIV_W'(1);
        end
      end
      // hardware retrigger from the neighbour's end count
      if (trig_hit) begin
        count_q  <= reload_q;
        active_q <= 1'b1;
        phase_q  <= '0;
      end
      if (lo_we) stage_q <= wdata;
      if (hi_we) begin
        reload_q <= {wdata, stage_q};
        count_q  <= {wdata, stage_q};
        phase_q  <= '0;
      end
      if (rd_lo) hold_q <= count_q[CNT_W-1:DATA_W];
      // control writes override everything else
      if (ctrl_we) begin
        en_q   <= wdata[0];
        mode_q <= wdata[3:2];
        src_q  <= wdata[7:4];
        div_q  <= wdata[15:8];
        if (!wdata[0]) begin
          active_q <= 1'b0;
        end else if (start_req) begin
          active_q <= 1'b1;
          count_q  <= reload_q;
          phase_q  <= '0;
        end
      end
    end
  end

  assign ctrl_word = {{(DATA_W-16){1'b0}}, div_q, src_q, mode_q, active_q, en_q};
  assign count_lo  = count_q[DATA_W-1:0];
  assign hold_hi   = hold_q;

  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt && !trig_hit |=> !end_evt);                                     // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt && !trig_hit && !hi_we && !ctrl_we |=> count_q == '0);          // R4
  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && !wdata[0] |=> !active_q);                                    // R7
  AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    prev_end && !en_q && !ctrl_we && !active_q |=> !active_q);              // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q && !hi_we && !trig_hit && !ctrl_we |=> $stable(count_q));     // R7
  AST_TRIG_NO_SELF_START: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && (wdata[3:2] == MODE_TRIG) && !active_q && !trig_hit |=> !active_q); // R6

endmodule

// File: rtl/wdtb_wdsel.sv
module wdtb_wdsel #(
  parameter int NUM_CNT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_we,
  input  logic [NUM_CNT-1:0] sel_in,
  input  logic [NUM_CNT-1:0] end_vec,
  output logic [NUM_CNT-1:0] sel_q,
  output logic               wdt_rst
);

  logic hit;
  assign hit = |(sel_q & end_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      wdt_rst <= 1'b0;
    end else begin
      if (sel_we) sel_q <= sel_in;
      wdt_rst <= hit;
    end
  end

  AST_WDT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(|(sel_q & end_vec)));                                 // R9
  AST_WDT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |=> !wdt_rst);                                            // R9

endmodule

// File: rtl/wdtb_top.sv
module wdtb_top
  import wdtb_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wdt_rst
);

  localparam int IDX_W = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(NUM_CNT * 16);

  logic [IDX_W-1:0]  idx;
  logic [3:0]        ofs;
  logic [NUM_CNT-1:0] end_vec;
  logic [NUM_CNT-1:0] sel_q;
  logic [DATA_W-1:0] ctrl_w [NUM_CNT];
  logic [DATA_W-1:0] lo_w   [NUM_CNT];
  logic [DATA_W-1:0] hi_w   [NUM_CNT];

  assign idx = addr[ADDR_W-1:4];
  assign ofs = addr[3:0];

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic hit_i;
    logic prev_end_i;
    assign hit_i = (idx == IDX_W'(i));
    if (i == 0) begin : g_first
      assign prev_end_i = 1'b0;
    end else begin : g_chain
      assign prev_end_i = end_vec[i-1];
    end
    wdtb_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (wr_en && hit_i && (ofs == CTRL_OFS)),
      .lo_we     (wr_en && hit_i && (ofs == LO_OFS)),
      .hi_we     (wr_en && hit_i && (ofs == HI_OFS)),
      .rd_lo     (rd_en && hit_i && (ofs == LO_OFS)),
      .wdata     (wdata),
      .prev_end  (prev_end_i),
      .ctrl_word (ctrl_w[i]),
      .count_lo  (lo_w[i]),
      .hold_hi   (hi_w[i]),
      .end_evt   (end_vec[i])
    );
  end

  wdtb_wdsel #(.NUM_CNT(NUM_CNT)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_we  (wr_en && (addr == SEL_ADDR)),
    .sel_in  (wdata[NUM_CNT-1:0]),
    .end_vec (end_vec),
    .sel_q   (sel_q),
    .wdt_rst (wdt_rst)
  );

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (idx == IDX_W'(i)) begin
        if (ofs == CTRL_OFS)    rdata = ctrl_w[i];
        else if (ofs == LO_OFS) rdata = lo_w[i];
        else if (ofs == HI_OFS) rdata = hi_w[i];
      end
    end
    if (addr == SEL_ADDR) rdata = DATA_W'(sel_q);
  end

  AST_WDT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst && !end_vec[0] |=> !wdt_rst || $past(|end_vec));                // R9

endmodule

// File: tb/wdtb_top_tb.sv
`timescale 1ns/1ps
module wdtb_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdt_rst;

  int tests = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdtb_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wdt_rst(wdt_rst)
  );

  always @(negedge clk) if (rst_n && wdt_rst) pulses++;

  // {is_write, addr, data, expected}
  localparam int NV = 14;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h24, 32'hDEADBEEF, 32'h0},
    {1'b1, 8'h28, 32'h12345678, 32'h0},
    {1'b0, 8'h24, 32'h0,        32'hDEADBEEF},
    {1'b0, 8'h28, 32'h0,        32'h12345678},
    {1'b1, 8'h24, 32'h00000055, 32'h0},
    {1'b0, 8'h24, 32'h0,        32'hDEADBEEF},
    {1'b1, 8'h20, 32'h000012F4, 32'h0},
    {1'b0, 8'h20, 32'h0,        32'h000012F4},
    {1'b1, 8'h20, 32'hFFFF0302, 32'h0},
    {1'b0, 8'h20, 32'h0,        32'h00000300},
    {1'b1, 8'h40, 32'h0000000A, 32'h0},
    {1'b0, 8'h40, 32'h0,        32'h0000000A},
    {1'b1, 8'h40, 32'h0,        32'h0},
    {1'b0, 8'h40, 32'h0,        32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick();
    wr(8'h00, 32'h0200);
    wr(8'h00, 32'h0201);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    chk("R10 wdt_rst", {31'b0, wdt_rst}, 32'h0);
    rd(8'h10, v); chk("R10 ctrl1", v, 32'h0);
    rd(8'h14, v); chk("R10 count1", v, 32'h0);
    rd(8'h40, v); chk("R10 mask", v, 32'h0);

    // register vectors: R1 field layout, R2 staging, R3 capture
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][71:64], v);
        chk($sformatf("R1,R2,R3 vector %0d", i), v, VEC[i][31:0]);
      end
    end

    // R4 divider 4 countdown on counter 2
    wr(8'h24, 32'd100); wr(8'h28, 32'h0);
    wr(8'h20, 32'h0401);
    idle(39);
    rd(8'h24, v); chk("R4 count after 39 clk div4", v, 32'd91);
    rd(8'h20, v); chk("R5 running flag set", v, 32'h0403);
    // R7 disable freezes the count
    wr(8'h20, 32'h0400);
    idle(10);
    rd(8'h24, v); chk("R7 frozen count", v, 32'd90);
    rd(8'h20, v); chk("R7 running flag cleared", v, 32'h0400);

    // R4 divider 0 acts as 2
    wr(8'h24, 32'd50); wr(8'h28, 32'h0);
    wr(8'h20, 32'h0001);
    idle(9);
    rd(8'h24, v); chk("R4 divider floor", v, 32'd46);
    wr(8'h20, 32'h0);

    // R3 atomic split read across a high-word borrow, counter 3
    wr(8'h34, 32'd2); wr(8'h38, 32'd1);
    wr(8'h30, 32'h0201);
    rd(8'h34, v); chk("R3 low first sample", v, 32'd2);
    idle(10);
    rd(8'h38, v); chk("R3 held high word", v, 32'd1);
    rd(8'h34, v); chk("R3 low after borrow", v, 32'hFFFFFFFC);
    rd(8'h38, v); chk("R3 high after borrow", v, 32'd0);
    wr(8'h30, 32'h0);

    // R6/R8/R9 chained refresh and expiry
    wr(8'h40, 32'h2);
    wr(8'h04, 32'h0); wr(8'h08, 32'h0);
    wr(8'h14, 32'd20); wr(8'h18, 32'h0);
    wr(8'h10, 32'h025D);
    rd(8'h10, v); chk("R6 enable does not start", v, 32'h025D);
    wr(8'h00, 32'h0201);
    idle(30);
    rd(8'h14, v); chk("R6 triggered countdown", v, 32'd6);
    kick();
    idle(1);
    rd(8'h14, v); chk("R8 refresh reloads", v, 32'd20);
    chk("R9 no pulse before expiry", pulses, 32'd0);
    idle(39);
    chk("R9 low at end event", {31'b0, wdt_rst}, 32'h0);
    idle(1);
    chk("R9 pulse high", {31'b0, wdt_rst}, 32'h1);
    idle(1);
    chk("R9 pulse one cycle", {31'b0, wdt_rst}, 32'h0);
    rd(8'h10, v); chk("R6 stops at zero", v, 32'h025D);
    rd(8'h14, v); chk("R5 count held at zero", v, 32'h0);
    chk("R9 pulse count", pulses, 32'd1);

    // R7 trigger ignored while disabled
    wr(8'h10, 32'h025C);
    kick();
    idle(2);
    rd(8'h10, v); chk("R7 trigger ignored flag", v, 32'h025C);
    rd(8'h14, v); chk("R7 trigger ignored count", v, 32'h0);

    // R9 mask zero suppresses output
    wr(8'h40, 32'h0);
    wr(8'h10, 32'h025D);
    kick();
    idle(50);
    chk("R9 masked no pulse", pulses, 32'd1);
    rd(8'h10, v); chk("R6 expired again", v, 32'h025D);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule